// File: doc/BRIEF.md
# Adaptive Prefetch Run-Ahead Token Queue

This block limits how far a prefetching stream may run ahead of the stream that issues the matching loads. The prefetching producer hands in one token (a put) for each loop iteration in which it prefetches. The loading consumer takes one token (a get) for each iteration in which it loads. The queue's current size is the largest number of tokens that may be outstanding, so it sets the run-ahead distance.

The size is not fixed. Each prefetch is classified by an event pulse. A prefetch is late when its data came back after the matching load had already issued. It is useful when its data came back before that load. After every sixteen classified events the block makes one decision:

- If the attached 8-entry prefetch buffer reports that all entries are taken, the size holds.
- Otherwise, if twice the late count exceeds the useful count, the size grows by one.
- In every other case, the size shrinks by one.

The tallies then start again from zero.

Top module: `slip_ctl_queue`

## Requirements
- R1: After reset the size output is 4, put_ready is 1 and get_ready is 0.
- R2: A put is taken on a clock edge only while the token count is below the current size. When the count has reached the size, put_ready is 0 and an offered put does not change the count.
- R3: A get is taken only while the count is nonzero. get_ready is 0 at count zero, and an offered get then leaves the count at zero.
- R4: A put and a get taken on the same edge leave the token count unchanged.
- R5: One decision is made after every 16 events (evt_valid=1), counting both kinds. The size changes only in the cycle that follows the edge which takes the 16th event, and the tallies restart at zero after that edge. Idle cycles between events do not count.
- R6: When pfb_full=1 is sampled on the decision edge, the size stays the same. pfb_full has no effect on any other edge.
- R7: With pfb_full=0 on the decision edge, if 2*late > useful within the window, the size rises by one. An event with evt_late=1 is late; one with evt_late=0 is useful.
- R8: With pfb_full=0 on the decision edge, if 2*late <= useful, the size falls by one.
- R9: The size saturates: it never rises above 32 and never falls below 1.
- R10: A shrink below the current count discards no token. Puts stay blocked until gets bring the count below the new size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release is expected to be synchronous to clk |
| put_valid | input | 1 | Producer offers one token |
| put_ready | output | 1 | Count is below the size, so a put is taken |
| get_valid | input | 1 | Consumer asks for one token |
| get_ready | output | 1 | Count is nonzero, so a get is taken |
| evt_valid | input | 1 | One prefetch has been classified this cycle |
| evt_late | input | 1 | Kind of the event: 1 late, 0 useful |
| pfb_full | input | 1 | Attached prefetch buffer has all entries occupied |
| size | output | 6 | Current queue size (run-ahead distance) |

## Verification
put_ready and get_ready are decoded from registered state. A put or get offered before an edge therefore shows its effect on both ready outputs one cycle later. The size register takes the decision on the edge that carries the 16th event, and the new value is visible right after that edge.

The bench changes inputs only on falling edges and compares every output on the next falling edge against a model in the bench. That model updates once per rising edge. As a result, every output is checked in every cycle, and a size change that comes one cycle early or late is caught.

The window sweep covers every late count from 0 to 16, which includes the 5/11 and 6/10 boundary. It also covers hold windows, runs to both saturation limits, and a shrink taken while the queue is full.

// File: rtl/slipq_pkg.sv
package slipq_pkg;

  // Outcome of one adaptation decision
  typedef enum logic [1:0] {
    ADJ_NONE   = 2'd0,
    ADJ_HOLD   = 2'd1,
    ADJ_GROW   = 2'd2,
    ADJ_SHRINK = 2'd3
  } adj_e;

endpackage

// File: rtl/slipq_tally.sv
// Counts classified prefetch events over a fixed window and produces the
// grow/shrink verdict on the event that closes the window.
module slipq_tally #(
  parameter int WINDOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_valid,
  input  logic evt_late,
  output logic decide_o,
  output logic grow_o
);

  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] evt_cnt_q, evt_cnt_d;
  logic [CW-1:0] late_q, late_d;
  logic [CW-1:0] late_tot, seen_tot, use_tot;
  logic          evt_en;
  logic          last_evt;

  assign evt_en   = evt_valid;
  assign seen_tot = evt_cnt_q + CW'(1);
  assign late_tot = late_q + CW'(evt_late);
  assign use_tot  = seen_tot - late_tot;
  assign last_evt = evt_valid && (seen_tot == CW'(WINDOW));

  assign decide_o = last_evt;
  assign grow_o   = ({late_tot, 1'b0} > {1'b0, use_tot});

  always_comb begin
    evt_cnt_d = evt_cnt_q;
    late_d    = late_q;
    if (last_evt) begin
      evt_cnt_d = '0;
      late_d    = '0;
    end else if (evt_valid) begin
      evt_cnt_d = seen_tot;
      late_d    = late_tot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_cnt_q <= '0;
      late_q    <= '0;
    end else if (evt_en) begin
      evt_cnt_q <= evt_cnt_d;
      late_q    <= late_d;
    end
  end

  // R5
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cnt_q < CW'(WINDOW));

  // R5
  window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decide_o |=> (evt_cnt_q == '0 && late_q == '0));

  // R7
  late_le_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    late_q <= evt_cnt_q);

endmodule

// File: rtl/slipq_size.sv
// Holds the adaptive queue size and applies one saturating step per decision.
module slipq_size
  import slipq_pkg::*;
#(
  parameter int MIN_SIZE = 1,
  parameter int MAX_SIZE = 32,
  parameter int RST_SIZE = 4,
  parameter int SW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          decide_i,
  input  logic          grow_i,
  input  logic          buf_full_i,
  output logic [SW-1:0] size_o
);

  logic [SW-1:0] size_q, size_d;
  logic          size_en;
  adj_e          adj;

  always_comb begin
    if (!decide_i)       adj = ADJ_NONE;
    else if (buf_full_i) adj = ADJ_HOLD;
    else if (grow_i)     adj = ADJ_GROW;
    else                 adj = ADJ_SHRINK;
  end

  assign size_en = (adj == ADJ_GROW) || (adj == ADJ_SHRINK);

  always_comb begin
    size_d = size_q;
    case (adj)
      ADJ_GROW:   if (size_q < SW'(MAX_SIZE)) size_d = size_q + SW'(1);
      ADJ_SHRINK: if (size_q > SW'(MIN_SIZE)) size_d = size_q - SW'(1);
      default:    size_d = size_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       size_q <= SW'(RST_SIZE);
    else if (size_en) size_q <= size_d;
  end

  assign size_o = size_q;

  // R9
  size_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q >= SW'(MIN_SIZE)) && (size_q <= SW'(MAX_SIZE)));

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_i && buf_full_i) |=> $stable(size_q));

  // R5
  no_decide_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !decide_i |=> $stable(size_q));

  // R9
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(size_q) |-> (size_q == $past(size_q) + SW'(1) ||
                          size_q == $past(size_q) - SW'(1)));

endmodule

// File: rtl/slipq_tokens.sv
// Outstanding-token counter gated by the current size.
module slipq_tokens #(
  parameter int MAX_SIZE = 32,
  parameter int SW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          put_valid_i,
  input  logic          get_valid_i,
  input  logic [SW-1:0] size_i,
  output logic          put_ready_o,
  output logic          get_ready_o
);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          put_fire, get_fire, cnt_en;

  assign put_ready_o = (cnt_q < size_i);
  assign get_ready_o = (cnt_q != '0);
  assign put_fire    = put_valid_i && put_ready_o;
  assign get_fire    = get_valid_i && get_ready_o;
  assign cnt_en      = put_fire ^ get_fire;

  always_comb begin
    cnt_d = cnt_q;
    if (put_fire && !get_fire)      cnt_d = cnt_q + SW'(1);
    else if (get_fire && !put_fire) cnt_d = cnt_q - SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SW'(MAX_SIZE));

  // R2
  blocked_put_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (put_valid_i && !put_ready_o) |=> (cnt_q <= $past(cnt_q)));

  // R3
  empty_get_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!get_ready_o && !put_valid_i) |=> (cnt_q == '0));

  // R10
  over_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= size_i) |-> !put_ready_o);

endmodule

// File: rtl/slip_ctl_queue.sv
// Adaptive run-ahead token queue between a prefetching and a loading stream.
module slip_ctl_queue #(
  parameter int MIN_SIZE = 1,
  parameter int MAX_SIZE = 32,
  parameter int RST_SIZE = 4,
  parameter int WINDOW   = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             put_valid,
  output logic                             put_ready,
  input  logic                             get_valid,
  output logic                             get_ready,
  input  logic                             evt_valid,
  input  logic                             evt_late,
  input  logic                             pfb_full,
  output logic [$clog2(MAX_SIZE+1)-1:0]    size
);

  localparam int SW = $clog2(MAX_SIZE + 1);

  logic          decide, grow;
  logic [SW-1:0] size_w;

  slipq_tally #(.WINDOW(WINDOW)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_late  (evt_late),
    .decide_o  (decide),
    .grow_o    (grow)
  );

  slipq_size #(
    .MIN_SIZE (MIN_SIZE),
    .MAX_SIZE (MAX_SIZE),
    .RST_SIZE (RST_SIZE),
    .SW       (SW)
  ) u_size (
    .clk        (clk),
    .rst_n      (rst_n),
    .decide_i   (decide),
    .grow_i     (grow),
    .buf_full_i (pfb_full),
    .size_o     (size_w)
  );

  slipq_tokens #(
    .MAX_SIZE (MAX_SIZE),
    .SW       (SW)
  ) u_tokens (
    .clk         (clk),
    .rst_n       (rst_n),
    .put_valid_i (put_valid),
    .get_valid_i (get_valid),
    .size_i      (size_w),
    .put_ready_o (put_ready),
    .get_ready_o (get_ready)
  );

  assign size = size_w;

  // R4
  pair_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (put_valid && put_ready && get_valid && get_ready) |=> (get_ready));

endmodule

// File: tb/slip_ctl_queue_bench.sv
`timescale 1ns/1ps
module slip_ctl_queue_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic put_valid, get_valid, evt_valid, evt_late, pfb_full;
  logic put_ready, get_ready;
  logic [5:0] size;

  int checks = 0;
  int errors = 0;
  int exp_size, exp_cnt, e_n, e_late;

  always #10 clk = ~clk;

  slip_ctl_queue u_slip_ctl_queue (
    .clk(clk), .rst_n(rst_n),
    .put_valid(put_valid), .put_ready(put_ready),
    .get_valid(get_valid), .get_ready(get_ready),
    .evt_valid(evt_valid), .evt_late(evt_late),
    .pfb_full(pfb_full), .size(size)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    cmp(req, "size", int'(size), exp_size);
    cmp(req, "put_ready", int'(put_ready), (exp_cnt < exp_size) ? 1 : 0);
    cmp(req, "get_ready", int'(get_ready), (exp_cnt != 0) ? 1 : 0);
  endtask

  // One cycle: inputs set after a falling edge, model updated for the rising edge,
  // outputs compared at the next falling edge.
  task automatic step(input logic pv, input logic gv, input logic ev,
                      input logic el, input logic fl, input string req);
    bit pa, ga;
    put_valid = pv; get_valid = gv; evt_valid = ev; evt_late = el; pfb_full = fl;
    pa = pv && (exp_cnt < exp_size);
    ga = gv && (exp_cnt != 0);
    @(posedge clk);
    exp_cnt = exp_cnt + (pa ? 1 : 0) - (ga ? 1 : 0);
    if (ev) begin
      e_n++;
      if (el) e_late++;
      if (e_n == 16) begin
        if (!fl) begin
          if (2 * e_late > (e_n - e_late)) begin
            if (exp_size < 32) exp_size++;
          end else if (exp_size > 1) exp_size--;
        end
        e_n = 0; e_late = 0;
      end
    end
    @(negedge clk);
    check_all(req);
  endtask

  // A full window of 16 events, the first nl of them late; optional idle gaps.
  task automatic window(input int nl, input logic fl, input bit gaps, input string req);
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 1'b0, 1'b1, (i < nl), fl, req);
      if (gaps && (i % 5 == 2)) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R5");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    put_valid = 0; get_valid = 0; evt_valid = 0; evt_late = 0; pfb_full = 0;
    exp_size = 4; exp_cnt = 0; e_n = 0; e_late = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2: fill past the size; the extra put is refused
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    // R4: full queue: put+get just drains one; then paired transfers hold count
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    // R3: drain and over-drain
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3");

    // R7 / R8: sweep every late count in a window, with and without gaps
    for (int nl = 0; nl <= 16; nl++)
      window(nl, 1'b0, (nl % 2 == 1), (2 * nl > 16 - nl) ? "R7" : "R8");

    // R6: buffer full on the decision edge holds the size
    window(16, 1'b1, 1'b0, "R6");
    window(0, 1'b1, 1'b1, "R6");

    // R9: saturate at the top, then at the bottom
    for (int w = 0; w < 32; w++) window(16, 1'b0, 1'b0, "R9");
    cmp("R9", "size at top", int'(size), 32);
    for (int w = 0; w < 34; w++) window(0, 1'b0, 1'b0, "R9");
    cmp("R9", "size at bottom", int'(size), 1);

    // R10: grow to 3, fill, shrink to 2 while holding 3 tokens
    window(16, 1'b0, 1'b0, "R10");
    window(16, 1'b0, 1'b0, "R10");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    window(0, 1'b0, 1'b0, "R10");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule